// File: doc/BRIEF.md
# SPI Master with Two-Stage Baud Divider

This block is a single-slave SPI controller that runs from the module clock. A start strobe hands it a transmit word. The block then lowers its active-low select line and toggles the serial clock at the chosen rate. It moves one bit out on the data-out line and one bit in from the data-in line in each serial clock period. When the last bit has been captured, it returns the received word together with a one-cycle completion pulse.

The serial clock rate comes from two fields, each three bits wide. A prescale field `p` and a power-of-two selector `s` together divide the module clock by `(p+1)·2^(s+1)`. When both fields are zero the divisor is 2, which is the fastest rate. Clock idle level and clock phase can each be chosen, so all four SPI modes work. A word is either 8 or 16 bits long and can be sent with either end first. All configuration inputs are captured when a transfer is accepted. Until the transfer finishes, nothing on those inputs has any effect.

Top module: `spi_mst_core`

## Requirements
- R1: The serial clock period equals `(baud_pre+1)·2^(baud_sel+1)` module-clock cycles. With `baud_pre=0, baud_sel=0` the period is 2 cycles.
- R2: While `ss_n` is high, `sclk` rests at the `cpol` level: low for `cpol=0`, high for `cpol=1`. After the final edge of a transfer, `sclk` is back at that level.
- R3: When `cpol` equals `cpha`, `miso` is captured on rising `sclk` edges and `mosi` changes on falling edges. When they differ, the roles of the two edges are swapped.
- R4: With `cpha=0`, the first data bit is already on `mosi` in the first cycle after `ss_n` goes low, before any `sclk` edge.
- R5: `wide=1` gives a 16-bit transfer and `wide=0` an 8-bit transfer. A transfer makes exactly 2·N `sclk` edges, where N is the word length.
- R6: `lsb_first=1` sends bit 0 first. `lsb_first=0` sends bit N-1 first. Received bits are placed in the same order.
- R7: `ss_n` stays low from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, and `ss_n` is high in that same cycle.
- R8: A start, or any change to the configuration or transmit word, while `busy` is high has no effect on the transfer in progress and does not start another one.
- R9: With `mosi` looped to `miso`, `rx_word` equals the transmitted word. For 8-bit transfers this is the low byte, and bits 15..8 read as zero.
- R10: During and after reset, `ss_n=1`, `sclk=0`, `done=0`, `busy=0` and `rx_word=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| tx_word | input | 16 | Word to transmit |
| baud_pre | input | 3 | Prescale field of the baud divisor |
| baud_sel | input | 3 | Power-of-two selector of the baud divisor |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| lsb_first | input | 1 | 1 = least significant bit first |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| rx_word | output | 16 | Received word, updated together with `done` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions rely on the module clock running and on reset being asserted before the first edge, so that every `$past` term sees defined values. They also assume the configuration inputs hold valid two-state levels whenever the block is idle, because the idle clock level follows `cpol` directly. The bench drives every input from reset onward and changes inputs only at falling clock edges. In the disturbance case it changes the configuration deliberately while the block is busy and keeps the start strobe away from the cycle in which `done` fires.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  localparam int PRE_W  = 3;
  localparam int SEL_W  = 3;
  // widest half period: (2^PRE_W) << (2^SEL_W - 1)
  localparam int HALF_W = PRE_W + 1 + (1 << SEL_W) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} xfer_st_e;

  // half of the serial clock period in module-clock cycles
  function automatic logic [HALF_W-1:0] half_period(input logic [PRE_W-1:0] pre,
                                                    input logic [SEL_W-1:0] sel);
    logic [HALF_W-1:0] base;
    base = HALF_W'(pre) + HALF_W'(1);
    return base << sel;
  endfunction
endpackage

// File: rtl/spi_mst_baud.sv
module spi_mst_baud #(
  parameter int HALF_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + HALF_W'(1);
  end

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> half != '0); // R1
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < half); // R1
endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter #(
  parameter int MAX_BITS   = 16,
  parameter int SHORT_BITS = 8,
  parameter int EDGE_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_in,
  input  logic                wide,
  input  logic                lsb,
  input  logic                cpha,
  input  logic [EDGE_W-1:0]   edge_cnt,
  input  logic                cap_evt,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_bits
);
  localparam int IDX_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] tx_q;
  logic [EDGE_W-1:0]   out_slot;
  logic [IDX_W-1:0]    top_idx;
  logic [IDX_W-1:0]    out_i;
  logic [IDX_W-1:0]    cap_i;

  // slot number -> bit position within the word
  function automatic logic [IDX_W-1:0] bit_pos(input logic lsb_f,
                                              input logic [IDX_W-1:0] last,
                                              input logic [IDX_W-1:0] slot);
    return lsb_f ? slot : last - slot;
  endfunction

  always_comb begin
    top_idx = wide ? IDX_W'(MAX_BITS-1) : IDX_W'(SHORT_BITS-1);
    if (cpha) out_slot = (edge_cnt == '0) ? '0 : (edge_cnt - EDGE_W'(1)) >> 1;
    else      out_slot = edge_cnt >> 1;
    if (out_slot > EDGE_W'(top_idx)) out_slot = EDGE_W'(top_idx);
    out_i = bit_pos(lsb, top_idx, IDX_W'(out_slot));
    cap_i = bit_pos(lsb, top_idx, IDX_W'(edge_cnt >> 1));
  end

  assign mosi = tx_q[out_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_bits <= '0;
    end else if (load) begin
      tx_q    <= tx_in;
      rx_bits <= '0;
    end else if (cap_evt) begin
      rx_bits[cap_i] <= miso;
    end
  end

  AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> cap_i <= top_idx); // R6
endmodule

// File: rtl/spi_mst_core.sv
module spi_mst_core
  import spi_mst_pkg::*;
#(
  parameter int MAX_BITS   = 16,
  parameter int SHORT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [PRE_W-1:0]    baud_pre,
  input  logic [SEL_W-1:0]    baud_sel,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                wide,
  input  logic                lsb_first,
  input  logic                miso,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                sclk,
  output logic                mosi,
  output logic                ss_n
);
  localparam int EDGE_W = $clog2(2*MAX_BITS + 1);

  xfer_st_e            state_q;
  logic                cpol_q, cpha_q, wide_q, lsb_q;
  logic [HALF_W-1:0]   half_q;
  logic [EDGE_W-1:0]   edge_cnt_q;
  logic [EDGE_W-1:0]   last_edge;
  logic [MAX_BITS-1:0] rx_bits;
  logic                tick;
  logic                accept;
  logic                edge_evt;
  logic                cap_evt;

  assign busy      = (state_q != ST_IDLE);
  assign accept    = (state_q == ST_IDLE) && start;
  assign edge_evt  = (state_q == ST_SHIFT) && tick;
  // capture on odd edges for phase 0, on even edges for phase 1
  assign cap_evt   = edge_evt && (edge_cnt_q[0] == cpha_q);
  assign last_edge = wide_q ? EDGE_W'(2*MAX_BITS-1) : EDGE_W'(2*SHORT_BITS-1);

  spi_mst_baud #(.HALF_W(HALF_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
  );

  spi_mst_shifter #(.MAX_BITS(MAX_BITS), .SHORT_BITS(SHORT_BITS), .EDGE_W(EDGE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_in(tx_word),
    .wide(wide_q), .lsb(lsb_q), .cpha(cpha_q), .edge_cnt(edge_cnt_q),
    .cap_evt(cap_evt), .miso(miso), .mosi(mosi), .rx_bits(rx_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      wide_q     <= 1'b0;
      lsb_q      <= 1'b0;
      half_q     <= half_period('0, '0);
      edge_cnt_q <= '0;
      sclk       <= 1'b0;
      ss_n       <= 1'b1;
      done       <= 1'b0;
      rx_word    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk <= cpol;
          ss_n <= 1'b1;
          if (start) begin
            cpol_q     <= cpol;
            cpha_q     <= cpha;
            wide_q     <= wide;
            lsb_q      <= lsb_first;
            half_q     <= half_period(baud_pre, baud_sel);
            edge_cnt_q <= '0;
            ss_n       <= 1'b0;
            state_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk       <= ~sclk;
            edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
            if (edge_cnt_q == last_edge) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state_q <= ST_IDLE;
            ss_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_bits;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SS_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_RELEASES_SS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ss_n && !busy); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sclk == $past(cpol)); // R2
  AST_FINAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sclk == cpol_q); // R2
  AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> sclk != $past(sclk)); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(half_q) && $stable(cpha_q) && $stable(wide_q))); // R8
endmodule

// File: tb/spi_mst_core_tb.sv
module spi_mst_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic [2:0]  baud_pre = '0, baud_sel = '0;
  logic        cpol = 1'b0, cpha = 1'b0, wide = 1'b0, lsb_first = 1'b0;
  logic        busy, done, sclk, mosi, ss_n;
  logic [15:0] rx_word;

  int n_checks = 0;
  int n_fail = 0;
  int cyc_total = 0;

  always #10 clk = ~clk; // 50 MHz

  spi_mst_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .baud_pre(baud_pre), .baud_sel(baud_sel), .cpol(cpol), .cpha(cpha),
    .wide(wide), .lsb_first(lsb_first), .miso(mosi), .busy(busy), .done(done),
    .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
  );

  // {pre, sel, cpol, cpha, wide, lsb_first, tx}
  localparam logic [25:0] VECS [0:7] = '{
    {3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A5},
    {3'd0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h003C},
    {3'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'hB2C7},
    {3'd2, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1E69},
    {3'd7, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 16'h8001},
    {3'd1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0081},
    {3'd3, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h5AF0},
    {3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF3E}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc_total, 150000);
      finish_run();
    end
  end

  task automatic run_xfer(input logic [25:0] v, input bit disturb);
    logic [2:0]  p = v[25:23];
    logic [2:0]  s = v[22:20];
    logic        pol = v[19];
    logic        pha = v[18];
    logic        wd  = v[17];
    logic        lf  = v[16];
    logic [15:0] tx  = v[15:0];
    int nb = wd ? 16 : 8;
    int div = (p + 1) * (1 << (s + 1));
    int cyc = 0, edges = 0, capn = 0, t1 = 0, t3 = 0;
    bit ss_bad = 0;
    logic prev;
    logic [15:0] got = '0, exp_seq = '0, exp_rx;
    for (int i = 0; i < nb; i++) exp_seq[i] = lf ? tx[i] : tx[nb-1-i];
    exp_rx = wd ? tx : {8'h00, tx[7:0]};

    @(negedge clk);
    baud_pre = p; baud_sel = s; cpol = pol; cpha = pha; wide = wd;
    lsb_first = lf; tx_word = tx;
    repeat (3) @(negedge clk);
    check(sclk == pol && ss_n, "R2 idle level", sclk, pol);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!ss_n && busy, "R7 select asserted", ss_n, 0);
    if (!pha) check(mosi == exp_seq[0], "R4 first bit early", mosi, exp_seq[0]);
    prev = sclk;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!done && ss_n) ss_bad = 1;
      if (sclk != prev) begin
        edges++;
        if (edges == 1) t1 = cyc;
        if (edges == 3) t3 = cyc;
        // R3: capture on rising edge iff cpol == cpha
        if (sclk == (pol ~^ pha)) begin
          if (capn < 16) got[capn] = mosi;
          capn++;
        end
        if (disturb && edges == 3) begin
          start = 1'b1; tx_word = ~tx; cpol = ~pol; cpha = ~pha;
          wide = ~wd; lsb_first = ~lf; baud_pre = 3'd5; baud_sel = 3'd4;
        end
        if (disturb && edges == 5) start = 1'b0;
      end
      prev = sclk;
    end
    check(done == 1'b1, "R7 done reached", done, 1);
    check(ss_n == 1'b1 && !ss_bad, "R7 select held until done", ss_bad, 0);
    check(t3 - t1 == div, "R1 sclk period", t3 - t1, div);
    check(edges == 2 * nb, "R5 edge count", edges, 2 * nb);
    check(capn == nb && got == exp_seq, "R6 R3 bit sequence", got, exp_seq);
    check(rx_word == exp_rx, "R9 loopback word", rx_word, exp_rx);
    check(sclk == pol, "R2 final level", sclk, pol);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    if (disturb) begin
      start = 1'b0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!ss_n || done) ss_bad = 1;
      end
      check(!ss_bad, "R8 no second transfer", ss_bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ss_n == 1'b1 && sclk == 1'b0 && done == 1'b0 && busy == 1'b0 && rx_word == '0,
          "R10 reset state", {ss_n, sclk, done, busy}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ss_n == 1'b1 && busy == 1'b0, "R10 after release", ss_n, 1);
    for (int i = 0; i < 8; i++) run_xfer(VECS[i], 1'b0);
    // R8: start and config churn during a transfer
    run_xfer({3'd0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'hC35A}, 1'b1);
    // R1 reset-default divisor again after the disturbance
    run_xfer({3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7E81}, 1'b0);
    finish_run();
  end
endmodule